// File: doc/BRIEF.md
# Text-Mode Character Pixel Generator

This block turns the pixel coordinates produced by a 640x480 display timing generator into a 12-bit colour for a text screen. The screen is tiled with 8x8 character cells, 80 across and 60 down. A character store holds one 7-bit code per cell. For each pixel the block fetches the code of the cell under the beam and uses it to look up one dot in a glyph ROM. A set dot is drawn white and a clear dot is drawn in the blue background colour.

The timing generator drives `pixRow` and `pixCol` once per pixel clock, and the colour comes out a fixed number of clocks later, so the sync signals only need the same fixed delay. A host places text through a single write port that addresses the character store by cell index. Pixels outside the visible area are driven black. After reset every cell reads as a space.

Top module: `text_pixel_gen`

## Requirements
- R1: The colour for the coordinates sampled at clock edge k is registered at edge k+2. The output reflects each new coordinate three clocks after it is driven, and one result follows another on every clock.
- R2: The cell row is pixRow[8:3] and the cell column is pixCol[9:3]. The character store index of a cell is cellRow*80 + cellCol.
- R3: pixRow[2:0] selects the glyph line and pixCol[2:0] selects the dot in that line. Dot column 0 is bit 7 (the MSB) of the line byte, and the glyph address is {code, line, dot}.
- R4: Inside the visible area the colour is 12'hFFF when the dot is set and 12'h00F when it is clear, packed as red[11:8], green[7:4], blue[3:0].
- R5: When pixRow >= 480 or pixCol >= 640, the colour is 12'h000.
- R6: Codes 0x00 to 0x1F draw a cell with no dots set, even when that cell held a solid glyph before.
- R7: pixColor is 12'h000 while rstN is low. After reset every cell reads as code 0x20 (space, no dots), so every visible pixel is 12'h00F.
- R8: While wrEn is high and wrAddr < 4800, a rising edge stores wrData at wrAddr. Later scans of that cell show the new code, and a second write to the same cell replaces the first.
- R9: The built-in glyph set is as follows. 0x7F has every dot set. 0x21 has line bytes 18,18,18,18,00,18,18,00. 0x41 has 3C,66,66,7E,66,66,66,00. 0x48 has 66,66,66,7E,66,66,66,00 (lines 0 to 7, hex). Every other code draws blank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixRow | input | 9 | Current pixel row from the timing generator |
| pixCol | input | 10 | Current pixel column from the timing generator |
| wrEn | input | 1 | Host write strobe for the character store |
| wrAddr | input | 13 | Cell index to write (row*80 + column) |
| wrData | input | 7 | Character code to store |
| pixColor | output | 12 | Pixel colour, rrrr_gggg_bbbb |

## Verification
The bench builds the block with its default parameters: 80x60 cells, 8x8 glyphs and a 640x480 visible area. These values select the shift-and-add form of the cell index. They also make reachable the last cell index 4799, the bottom-right visible pixel (479,639), and the rows 480 to 511 that the 9-bit row input can carry beyond the visible area. With these sizes, the bench can check dot ordering inside centred glyphs, both screen edges, and the three-clock pipeline alignment with coordinates that change on every clock.

// File: rtl/text_pkg.sv
package text_pkg;

  localparam logic [11:0] COLOR_FG    = 12'hFFF;
  localparam logic [11:0] COLOR_BG    = 12'h00F;
  localparam logic [11:0] COLOR_BLACK = 12'h000;
  localparam logic [6:0]  CODE_SPACE     = 7'h20;
  localparam logic [6:0]  CODE_GLYPH_MIN = 7'h20;

  // Strobes from control to datapath
  typedef struct packed {
    logic memWr;    // qualified write into the character store
    logic showOut;  // pixel at the output stage lies in the visible area
  } ctrlStb_t;

endpackage

// File: rtl/text_glyph_rom.sv
module text_glyph_rom
  import text_pkg::*;
#(
  parameter int CODE_W     = 7,
  parameter int GLYPH_BITS = 3,
  localparam int GA_W      = CODE_W + 2 * GLYPH_BITS
) (
  input  logic [GA_W-1:0] glyphAddr,
  output logic            dotOn
);

  logic [CODE_W-1:0]     code;
  logic [GLYPH_BITS-1:0] line;
  logic [GLYPH_BITS-1:0] dot;
  logic [7:0]            lineBits;

  assign code = glyphAddr[GA_W-1 -: CODE_W];
  assign line = glyphAddr[2*GLYPH_BITS-1 -: GLYPH_BITS];
  assign dot  = glyphAddr[GLYPH_BITS-1:0];

  // Small test subset; every other code is blank
  always_comb begin
    lineBits = 8'h00;
    case (code)
      7'h7F: lineBits = 8'hFF;
      7'h21: lineBits = (line == 3'd4 || line == 3'd7) ? 8'h00 : 8'h18;
      7'h41: begin
        case (line)
          3'd0:    lineBits = 8'h3C;
          3'd3:    lineBits = 8'h7E;
          3'd7:    lineBits = 8'h00;
          default: lineBits = 8'h66;
        endcase
      end
      7'h48: begin
        case (line)
          3'd3:    lineBits = 8'h7E;
          3'd7:    lineBits = 8'h00;
          default: lineBits = 8'h66;
        endcase
      end
      default: lineBits = 8'h00;
    endcase
  end

  // Leftmost dot is the MSB (R3)
  assign dotOn = lineBits[~dot];

endmodule

// File: rtl/text_ctrl.sv
module text_ctrl
  import text_pkg::*;
#(
  parameter int ROW_W  = 9,
  parameter int COL_W  = 10,
  parameter int ACT_W  = 640,
  parameter int ACT_H  = 480,
  parameter int ADDR_W = 13,
  parameter int DEPTH  = 4800,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ROW_W-1:0]  pixRow,
  input  logic [COL_W-1:0]  pixCol,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output ctrlStb_t          stb
);

  localparam logic [ROW_W-1:0]  ACT_H_V = ROW_W'(ACT_H);
  localparam logic [COL_W-1:0]  ACT_W_V = COL_W'(ACT_W);
  localparam logic [ADDR_W-1:0] DEPTH_V = ADDR_W'(DEPTH);

  logic              inArea;
  logic [STAGES-1:0] showPipe;

  assign inArea = (pixRow < ACT_H_V) && (pixCol < ACT_W_V);

  // Visible flag travels alongside the address/code stages
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) showPipe <= '0;
    else       showPipe <= {showPipe[STAGES-2:0], inArea};
  end

  assign stb.showOut = showPipe[STAGES-1];
  assign stb.memWr   = wrEn && (wrAddr < DEPTH_V);

endmodule

// File: rtl/text_datapath.sv
module text_datapath
  import text_pkg::*;
#(
  parameter int ROW_W      = 9,
  parameter int COL_W      = 10,
  parameter int CELL_COLS  = 80,
  parameter int CELL_ROWS  = 60,
  parameter int GLYPH_BITS = 3,
  parameter int CODE_W     = 7,
  localparam int DEPTH      = CELL_COLS * CELL_ROWS,
  localparam int ADDR_W     = $clog2(DEPTH),
  localparam int CELL_ROW_W = ROW_W - GLYPH_BITS,
  localparam int CELL_COL_W = COL_W - GLYPH_BITS,
  localparam int GA_W       = CODE_W + 2 * GLYPH_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ROW_W-1:0]  pixRow,
  input  logic [COL_W-1:0]  pixCol,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CODE_W-1:0] wrData,
  input  ctrlStb_t          stb,
  output logic [11:0]       pixColor
);

  localparam logic [ADDR_W-1:0] DEPTH_V = ADDR_W'(DEPTH);

  logic [CELL_ROW_W-1:0] cellRow;
  logic [CELL_COL_W-1:0] cellCol;
  logic [ADDR_W-1:0]     cellAddr;

  assign cellRow = pixRow[ROW_W-1:GLYPH_BITS];
  assign cellCol = pixCol[COL_W-1:GLYPH_BITS];

  // Cell index: shift-add for 80 columns, multiplier otherwise
  generate
    if (CELL_COLS == 80) begin : g_shiftAdd
      assign cellAddr = (ADDR_W'(cellRow) << 6) + (ADDR_W'(cellRow) << 4)
                      + ADDR_W'(cellCol);
    end else begin : g_mult
      assign cellAddr = ADDR_W'(cellRow) * ADDR_W'(CELL_COLS) + ADDR_W'(cellCol);
    end
  endgenerate

  // Character store: data array without reset, plus a written flag per cell
  logic [CODE_W-1:0] cellMem [DEPTH];
  logic [DEPTH-1:0]  filled;

  always_ff @(posedge clk) begin
    if (stb.memWr) cellMem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          filled <= '0;
    else if (stb.memWr) filled[wrAddr] <= 1'b1;
  end

  // Stage 1: registered read address and glyph coordinates
  logic [ADDR_W-1:0]     rdAddr;
  logic [GLYPH_BITS-1:0] gRowS1, gColS1, gRowS2, gColS2;
  logic [CODE_W-1:0]     rdCode, codeReg;
  logic                  dotOn;

  always_comb begin
    rdCode = CODE_SPACE;
    if (rdAddr < DEPTH_V) begin
      if (filled[rdAddr]) rdCode = cellMem[rdAddr];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAddr   <= '0;
      gRowS1   <= '0;
      gColS1   <= '0;
      gRowS2   <= '0;
      gColS2   <= '0;
      codeReg  <= CODE_SPACE;
      pixColor <= COLOR_BLACK;
    end else begin
      rdAddr   <= cellAddr;
      gRowS1   <= pixRow[GLYPH_BITS-1:0];
      gColS1   <= pixCol[GLYPH_BITS-1:0];
      codeReg  <= rdCode;   // stage 2: code registered once more
      gRowS2   <= gRowS1;
      gColS2   <= gColS1;
      pixColor <= stb.showOut ? (dotOn ? COLOR_FG : COLOR_BG) : COLOR_BLACK;
    end
  end

  text_glyph_rom #(
    .CODE_W    (CODE_W),
    .GLYPH_BITS(GLYPH_BITS)
  ) u_glyph (
    .glyphAddr(GA_W'({codeReg, gRowS2, gColS2})),
    .dotOn    (dotOn)
  );

  assert_blank_low_codes_R6: assert property (@(posedge clk) disable iff (!rstN)
    (codeReg < CODE_GLYPH_MIN) |-> !dotOn);

  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.memWr |=> (filled[$past(wrAddr)] && cellMem[$past(wrAddr)] == $past(wrData)));

endmodule

// File: rtl/text_pixel_gen.sv
module text_pixel_gen
  import text_pkg::*;
#(
  parameter int ROW_W      = 9,
  parameter int COL_W      = 10,
  parameter int CELL_COLS  = 80,
  parameter int CELL_ROWS  = 60,
  parameter int GLYPH_BITS = 3,
  parameter int CODE_W     = 7,
  parameter int ACT_W      = 640,
  parameter int ACT_H      = 480,
  localparam int DEPTH     = CELL_COLS * CELL_ROWS,
  localparam int ADDR_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ROW_W-1:0]  pixRow,
  input  logic [COL_W-1:0]  pixCol,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CODE_W-1:0] wrData,
  output logic [11:0]       pixColor
);

  ctrlStb_t stb;

  text_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .ACT_W(ACT_W), .ACT_H(ACT_H),
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .STAGES(2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pixRow(pixRow), .pixCol(pixCol),
    .wrEn(wrEn), .wrAddr(wrAddr), .stb(stb)
  );

  text_datapath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .CELL_COLS(CELL_COLS), .CELL_ROWS(CELL_ROWS),
    .GLYPH_BITS(GLYPH_BITS), .CODE_W(CODE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .pixRow(pixRow), .pixCol(pixCol),
    .wrAddr(wrAddr), .wrData(wrData), .stb(stb), .pixColor(pixColor)
  );

  // Edges since reset, so the port checks below look back only over loaded stages
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  assert_offscreen_black_R5: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3 && ($past(pixRow, 3) >= ROW_W'(ACT_H) || $past(pixCol, 3) >= COL_W'(ACT_W)))
    |-> (pixColor == COLOR_BLACK));

  assert_visible_two_colours_R4: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3 && $past(pixRow, 3) < ROW_W'(ACT_H) && $past(pixCol, 3) < COL_W'(ACT_W))
    |-> (pixColor == COLOR_FG || pixColor == COLOR_BG));

endmodule

// File: tb/tb_text_pixel_gen.sv
module tb_text_pixel_gen;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  pixRow = '0;
  logic [9:0]  pixCol = '0;
  logic        wrEn = 1'b0;
  logic [12:0] wrAddr = '0;
  logic [6:0]  wrData = '0;
  logic [11:0] pixColor;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  text_pixel_gen dut (
    .clk(clk), .rstN(rstN), .pixRow(pixRow), .pixCol(pixCol),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .pixColor(pixColor)
  );

  // {row, col, expected colour}
  localparam logic [30:0] VEC [NVEC] = '{
    {9'd232, 10'd272, 12'h00F},  // R3 'H' line0 dot0 (bit7 of 66)
    {9'd232, 10'd273, 12'hFFF},  // R3 'H' line0 dot1
    {9'd235, 10'd278, 12'hFFF},  // R3 'H' line3 dot6 (7E)
    {9'd235, 10'd279, 12'h00F},  // R3 'H' line3 dot7
    {9'd239, 10'd273, 12'h00F},  // R9 'H' line7 blank
    {9'd232, 10'd282, 12'hFFF},  // R2 'A' next cell, line0 dot2 (3C)
    {9'd232, 10'd281, 12'h00F},  // R2 'A' line0 dot1
    {9'd0,   10'd0,   12'hFFF},  // R9 solid at cell 0
    {9'd7,   10'd7,   12'hFFF},  // R9 solid last dot
    {9'd472, 10'd635, 12'hFFF},  // R2 '!' at cell 4799 line0 dot3
    {9'd476, 10'd635, 12'h00F},  // R9 '!' line4 blank
    {9'd479, 10'd639, 12'h00F},  // R4 last visible pixel
    {9'd480, 10'd0,   12'h000},  // R5 below visible rows
    {9'd0,   10'd640, 12'h000},  // R5 right of visible columns
    {9'd511, 10'd1023,12'h000},  // R5 far corner
    {9'd160, 10'd160, 12'h00F},  // R7 unwritten cell
    {9'd9,   10'd1,   12'h00F}   // R9 code outside subset blank
  };

  task automatic check(input logic [11:0] act, input logic [11:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic putChar(input int row, input int col, input logic [6:0] code);
    @(negedge clk);
    wrEn   = 1'b1;
    wrAddr = 13'(row * 80 + col);
    wrData = code;
    @(negedge clk);
    wrEn   = 1'b0;
  endtask

  task automatic holdPixel(input int row, input int col);
    @(negedge clk);
    pixRow = 9'(row);
    pixCol = 10'(col);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pixColor, 12'h000, "R7 colour during reset");
    rstN = 1'b1;

    holdPixel(0, 0);
    check(pixColor, 12'h00F, "R7 space after reset");

    putChar(29, 34, 7'h48);
    putChar(29, 35, 7'h41);
    putChar(0, 0, 7'h7F);
    putChar(59, 79, 7'h21);
    putChar(1, 0, 7'h42);

    for (int i = 0; i < NVEC; i++) begin
      holdPixel(int'(VEC[i][30:22]), int'(VEC[i][21:12]));
      check(pixColor, VEC[i][11:0], $sformatf("R4 table vector %0d", i));
    end

    // R1: coordinates change every clock; results follow three clocks later
    holdPixel(480, 0);
    @(negedge clk); pixRow = 9'd0;   pixCol = 10'd0;    // solid -> FFF
    @(negedge clk); pixRow = 9'd232; pixCol = 10'd272;  // H dot0 -> 00F
    @(negedge clk); pixRow = 9'd0;   pixCol = 10'd640;  // offscreen -> 000
    check(pixColor, 12'h000, "R1 no early result");
    @(negedge clk); pixRow = 9'd232; pixCol = 10'd273;  // H dot1 -> FFF
    check(pixColor, 12'hFFF, "R1 first of stream");
    @(negedge clk);
    check(pixColor, 12'h00F, "R1 second of stream");
    @(negedge clk);
    check(pixColor, 12'h000, "R1 third of stream");
    @(negedge clk);
    check(pixColor, 12'hFFF, "R1 fourth of stream");

    // R6 and R8: overwrite solid cell with a control code
    putChar(0, 0, 7'h05);
    holdPixel(0, 0);
    check(pixColor, 12'h00F, "R6 low code blank dot0");
    holdPixel(7, 7);
    check(pixColor, 12'h00F, "R8 overwrite replaces solid");

    // R8: write back a solid glyph, visible again
    putChar(0, 0, 7'h7F);
    holdPixel(3, 4);
    check(pixColor, 12'hFFF, "R8 rewrite visible");

    // R7: reset clears the character store
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check(pixColor, 12'h000, "R7 colour in second reset");
    rstN = 1'b1;
    holdPixel(232, 273);
    check(pixColor, 12'h00F, "R7 store cleared by reset");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule